// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block turns a program-side access request into pin-level drive for an external memory bus. On that bus, address and data share the same lines at different times. Three static configuration inputs set up the bus:

- a data-width select, giving 8 or 16 data lines;
- a two-bit address-mode field, giving 20, 16 or 12 address lines, or no bus at all;
- an address-rebase enable, which subtracts the on-chip program memory size from every request address before it reaches the pins.

Every access runs the same four phases. First the address goes out with a one-cycle latch pulse. Next the shared lines are turned around for data. Then a read or write strobe is asserted for one cycle. Finally the bus returns to idle. A per-pin mask tells the pad logic which of the 20 bus pins are handed back to general-purpose I/O.

Requests arrive on a valid/ready interface. The requester holds `req_valid` and every request field stable until it sees `req_ready` high at a clock edge. `req_ready` is high only while the bus is idle, the mode is not "no bus", and the bus-release input is low. Read results come back as a single-cycle `rsp_valid` pulse. The response has no ready signal, so the consumer must take it in that cycle.

Top module: `xbus_mux_ctrl`

## Requirements
- R1: After reset, with the bus idle: `ale` is 0, `rd_n`, `wr_n`, `ub_n` and `lb_n` are 1, no output enable is set, and `req_ready` is 1 in any enabled mode with the release input low.
- R2: A request accepted at edge E0 gives the following sequence. `ale` is high with the address on every used pin in the cycle after E0. The shared lines turn around in the next cycle. The strobe is low in the cycle after that. The bus is idle again one cycle later. `req_ready` stays low from E0 until the bus is idle.
- R3: `cfg_amode` encodings are 00 = 20 address lines, 01 = 16, 10 = 12, 11 = bus disabled. Pin index 0..15 is `ad` line 0..15 and pin index 16..19 is `ahi` line 0..3. With the release input low and the bus idle, `io_free` is 0x00000, 0xF0000, 0xFF000 and 0xFFFFF for these four encodings. A pin is never driven while it is marked free.
- R4: In 16-line mode the `ahi` lines are never driven.
- R5: With 8-bit data (`cfg_wide`=0), only `ad[7:0]` carry data. The other used pins keep the address through the turnaround and strobe phases. A read returns `ad_i[7:0]` with the upper byte zero.
- R6: With 16-bit data (`cfg_wide`=1), write data appears on `ad[15:0]`. In 20-line mode the `ahi` lines keep address bits through the whole access.
- R7: With 16-bit data in 12-line mode, `ad[15:12]` are never driven, and read data bits 15:12 return 0.
- R8: With `cfg_shift`=0 the raw request address is used. With `cfg_shift`=1 the address used is the request address minus `ONCHIP_BYTES`, modulo 2^21.
- R9: The pins carry bits 20:1 of the effective byte address, limited to the used lines. During an access in 20-line mode, `ba0` carries bit 0; in other modes it stays 0.
- R10: With 16-bit data, a word access drives `ub_n`=`lb_n`=0. A single-byte access drives only `ub_n` low at an odd address, or only `lb_n` low at an even address, and places the byte on that lane. With 8-bit data both selects stay 1.
- R11: In bus-disabled mode, `req_ready` is 0, no strobe or enable is ever asserted, and `io_free` is all ones.
- R12: While `cfg_bus_off` is 1 and the bus is idle, `req_ready` is 0 and every used pin is also reported free. Pins already freed by the address mode stay free whether `cfg_bus_off` is 0 or 1.
- R13: `rsp_valid` pulses for one cycle right after the read strobe, carrying the sampled data. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wide | input | 1 | 1 = 16-bit data, 0 = 8-bit data |
| cfg_amode | input | 2 | Address-line mode, encoded as in R3 |
| cfg_shift | input | 1 | Subtract the on-chip memory size from addresses |
| cfg_bus_off | input | 1 | Release used pins while idle; block new requests |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_addr | input | 21 | Byte address of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_one_byte | input | 1 | Single-byte access (16-bit data only) |
| req_wdata | input | 16 | Write data; byte accesses use bits 7:0 |
| rsp_valid | output | 1 | Read data valid (one cycle, no back-pressure) |
| rsp_data | output | 16 | Read data |
| ad_o | output | 16 | Shared address/data line drive |
| ad_oe | output | 16 | Shared line output enables |
| ad_i | input | 16 | Shared line input values |
| ahi_o | output | 4 | Address bits 19:16 drive |
| ahi_oe | output | 4 | Output enables for address bits 19:16 |
| ale | output | 1 | Address latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ba0 | output | 1 | Byte address bit 0 |
| ub_n | output | 1 | Upper byte select, active low |
| lb_n | output | 1 | Lower byte select, active low |
| io_free | output | 20 | Per-pin mask, 1 = pin given to general-purpose I/O |

## Verification
The bound checker watches the protocol-level rules on every cycle:
- the latch pulse lasts one cycle;
- the strobes are one cycle long and never both low;
- no pin is driven while it is marked free;
- the `ahi` and upper `ad` lines stay silent in the modes that exclude them;
- disabled mode stays quiet;
- a response follows only a read strobe.

The exact values need the directed scenarios in the bench. These cover the address bits on the pins, address rebasing, `ba0` and the byte-select choice, lane placement of write data, masking of read data, and the exact `io_free` pattern for each mode and release setting.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int unsigned XB_BA_W  = 21;
  localparam int unsigned XB_DW    = 16;
  localparam int unsigned XB_PIN_W = 20;
  localparam int unsigned XB_HI_W  = XB_PIN_W - XB_DW;
  localparam int unsigned XB_NARROW = XB_DW / 2;
  localparam int unsigned XB_MID_W  = 16;
  localparam int unsigned XB_LOW_W  = 12;

  typedef enum logic [1:0] {
    AM_20  = 2'b00,
    AM_16  = 2'b01,
    AM_12  = 2'b10,
    AM_OFF = 2'b11
  } amode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_TURN,
    ST_STRB
  } phase_e;

  typedef struct packed {
    logic [XB_BA_W-1:0] addr;
    logic               write;
    logic               one_byte;
    logic [XB_DW-1:0]   wdata;
  } xreq_t;
endpackage

// File: rtl/xbus_addr_map.sv
module xbus_addr_map
  import xbus_pkg::*;
#(
  parameter int unsigned ONCHIP_BYTES = 32'h0002_0000
) (
  input  logic [XB_BA_W-1:0] raw_addr,
  input  logic               shift_en,
  output logic [XB_BA_W-1:0] eff_addr
);
  localparam logic [XB_BA_W-1:0] OFFS = XB_BA_W'(ONCHIP_BYTES);

  always_comb begin
    eff_addr = shift_en ? (raw_addr - OFFS) : raw_addr;
  end
endmodule

// File: rtl/xbus_lane_plan.sv
module xbus_lane_plan
  import xbus_pkg::*;
(
  input  amode_e              amode,
  input  logic                wide,
  output logic [XB_PIN_W-1:0] used,
  output logic [XB_DW-1:0]    mux
);
  for (genvar i = 0; i < XB_PIN_W; i++) begin : g_used
    localparam int unsigned IDX = i;
    always_comb begin
      used[i] = (amode == AM_20)
             || ((amode == AM_16) && (IDX < XB_MID_W))
             || ((amode == AM_12) && (IDX < XB_LOW_W));
    end
  end

  for (genvar j = 0; j < XB_DW; j++) begin : g_mux
    localparam int unsigned JDX = j;
    always_comb begin
      mux[j] = used[j] && (wide || (JDX < XB_NARROW));
    end
  end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  output phase_e phase,
  output logic   strobe_now
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= ST_IDLE;
    end else begin
      unique case (phase)
        ST_IDLE: if (start) phase <= ST_ADDR;
        ST_ADDR: phase <= ST_TURN;
        ST_TURN: phase <= ST_STRB;
        default: phase <= ST_IDLE;
      endcase
    end
  end

  assign strobe_now = (phase == ST_STRB);
endmodule

// File: rtl/xbus_mux_ctrl.sv
module xbus_mux_ctrl
  import xbus_pkg::*;
#(
  parameter int unsigned ONCHIP_BYTES = 32'h0002_0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wide,
  input  logic [1:0]          cfg_amode,
  input  logic                cfg_shift,
  input  logic                cfg_bus_off,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [XB_BA_W-1:0]  req_addr,
  input  logic                req_write,
  input  logic                req_one_byte,
  input  logic [XB_DW-1:0]    req_wdata,
  output logic                rsp_valid,
  output logic [XB_DW-1:0]    rsp_data,
  output logic [XB_DW-1:0]    ad_o,
  output logic [XB_DW-1:0]    ad_oe,
  input  logic [XB_DW-1:0]    ad_i,
  output logic [XB_HI_W-1:0]  ahi_o,
  output logic [XB_HI_W-1:0]  ahi_oe,
  output logic                ale,
  output logic                rd_n,
  output logic                wr_n,
  output logic                ba0,
  output logic                ub_n,
  output logic                lb_n,
  output logic [XB_PIN_W-1:0] io_free
);
  localparam int unsigned HALF = XB_DW / 2;

  amode_e              amode;
  phase_e              phase;
  logic                strobe_now;
  logic                accept;
  logic [XB_BA_W-1:0]  eff_addr;
  logic [XB_PIN_W-1:0] used;
  logic [XB_DW-1:0]    mux;
  logic [XB_PIN_W-1:0] mux_ext;
  logic [XB_PIN_W-1:0] pin_addr;
  logic [XB_PIN_W-1:0] addr_only;
  logic [XB_DW-1:0]    wd_lane;
  logic [XB_PIN_W-1:0] pins_o;
  logic [XB_PIN_W-1:0] pins_oe;
  xreq_t               lat;

  assign amode = amode_e'(cfg_amode);

  xbus_addr_map #(.ONCHIP_BYTES(ONCHIP_BYTES)) u_map (
    .raw_addr (req_addr),
    .shift_en (cfg_shift),
    .eff_addr (eff_addr)
  );

  xbus_lane_plan u_plan (
    .amode (amode),
    .wide  (cfg_wide),
    .used  (used),
    .mux   (mux)
  );

  xbus_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .phase      (phase),
    .strobe_now (strobe_now)
  );

  assign req_ready = (phase == ST_IDLE) && (amode != AM_OFF) && !cfg_bus_off;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat <= '0;
    end else if (accept) begin
      lat.addr     <= eff_addr;
      lat.write    <= req_write;
      lat.one_byte <= req_one_byte;
      lat.wdata    <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= strobe_now && !lat.write;
      if (strobe_now && !lat.write) rsp_data <= ad_i & mux;
    end
  end

  // Lane placement of write data
  always_comb begin
    if (!cfg_wide) begin
      wd_lane = {{HALF{1'b0}}, lat.wdata[HALF-1:0]};
    end else if (lat.one_byte) begin
      wd_lane = lat.addr[0] ? {lat.wdata[HALF-1:0], {HALF{1'b0}}}
                            : {{HALF{1'b0}}, lat.wdata[HALF-1:0]};
    end else begin
      wd_lane = lat.wdata;
    end
  end

  assign mux_ext   = {{XB_HI_W{1'b0}}, mux};
  assign pin_addr  = lat.addr[XB_BA_W-1:1] & used;
  assign addr_only = used & ~mux_ext;

  always_comb begin
    pins_o  = '0;
    pins_oe = '0;
    ale     = 1'b0;
    rd_n    = 1'b1;
    wr_n    = 1'b1;
    ba0     = 1'b0;
    ub_n    = 1'b1;
    lb_n    = 1'b1;
    unique case (phase)
      ST_ADDR: begin
        pins_o  = pin_addr;
        pins_oe = used;
        ale     = 1'b1;
      end
      ST_TURN, ST_STRB: begin
        pins_o  = (pin_addr & addr_only)
                | (lat.write ? ({{XB_HI_W{1'b0}}, wd_lane} & mux_ext) : '0);
        pins_oe = addr_only | (lat.write ? mux_ext : '0);
      end
      default: ;
    endcase
    if (phase != ST_IDLE) begin
      ba0 = (amode == AM_20) && lat.addr[0];
      if (cfg_wide) begin
        ub_n = lat.one_byte && !lat.addr[0];
        lb_n = lat.one_byte && lat.addr[0];
      end
    end
    if (strobe_now) begin
      rd_n = lat.write;
      wr_n = !lat.write;
    end
  end

  assign ad_o    = pins_o[XB_DW-1:0];
  assign ad_oe   = pins_oe[XB_DW-1:0];
  assign ahi_o   = pins_o[XB_PIN_W-1:XB_DW];
  assign ahi_oe  = pins_oe[XB_PIN_W-1:XB_DW];
  assign io_free = ~used | ((cfg_bus_off && (phase == ST_IDLE)) ? used : '0);
endmodule

// File: rtl/xbus_mux_chk.sv
module xbus_mux_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wide,
  input logic [1:0]  cfg_amode,
  input logic        ale,
  input logic        rd_n,
  input logic        wr_n,
  input logic [15:0] ad_oe,
  input logic [3:0]  ahi_oe,
  input logic [19:0] io_free,
  input logic        req_ready,
  input logic        rsp_valid
);
  a_r2_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);
  a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> !req_ready);
  a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |=> (rd_n && wr_n));
  a_r2_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  a_r3_no_drive_free: assert property (@(posedge clk) disable iff (!rst_n)
    (({ahi_oe, ad_oe} & io_free) == 20'h0));
  a_r4_hi_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_amode == 2'b01) |-> (ahi_oe == 4'h0));
  a_r7_top_nibble_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wide && cfg_amode == 2'b10) |-> (ad_oe[15:12] == 4'h0));
  a_r11_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_amode == 2'b11) |-> (!ale && rd_n && wr_n && !req_ready
                              && ad_oe == 16'h0 && ahi_oe == 4'h0
                              && io_free == 20'hFFFFF));
  a_r13_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!rd_n));
endmodule

bind xbus_mux_ctrl xbus_mux_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_wide  (cfg_wide),
  .cfg_amode (cfg_amode),
  .ale       (ale),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .ad_oe     (ad_oe),
  .ahi_oe    (ahi_oe),
  .io_free   (io_free),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid)
);

// File: tb/sim_xbus_mux_ctrl.sv
module sim_xbus_mux_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wide = 1'b1;
  logic [1:0]  cfg_amode = 2'b00;
  logic        cfg_shift = 1'b0;
  logic        cfg_bus_off = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [20:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_one_byte = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic [15:0] ad_o, ad_oe;
  logic [15:0] ad_i = '0;
  logic [3:0]  ahi_o, ahi_oe;
  logic        ale, rd_n, wr_n, ba0, ub_n, lb_n;
  logic [19:0] io_free;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // Observations per phase
  logic [19:0] a_pins, a_oe, d_pins, d_oe;
  logic        a_ale, a_ready, a_ba0, a_ub, a_lb, d_ale;
  logic        s_rd, s_wr, r_valid, i_rd, i_wr, i_ale;
  logic [15:0] r_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_mux_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_amode(cfg_amode),
    .cfg_shift(cfg_shift), .cfg_bus_off(cfg_bus_off),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_one_byte(req_one_byte), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i), .ahi_o(ahi_o), .ahi_oe(ahi_oe),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .ba0(ba0), .ub_n(ub_n), .lb_n(lb_n),
    .io_free(io_free)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_access(input logic [20:0] addr, input logic wr, input logic one_b,
                            input logic [15:0] wd, input logic [15:0] rd_in);
    @(negedge clk);
    req_addr = addr; req_write = wr; req_one_byte = one_b; req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    a_ale = ale; a_pins = {ahi_o, ad_o}; a_oe = {ahi_oe, ad_oe};
    a_ready = req_ready; a_ba0 = ba0; a_ub = ub_n; a_lb = lb_n;
    @(negedge clk);
    d_ale = ale; d_pins = {ahi_o, ad_o}; d_oe = {ahi_oe, ad_oe};
    ad_i = rd_in;
    @(negedge clk);
    s_rd = rd_n; s_wr = wr_n;
    @(negedge clk);
    r_valid = rsp_valid; r_data = rsp_data;
    i_rd = rd_n; i_wr = wr_n; i_ale = ale;
    ad_i = '0;
  endtask

  task automatic t_reset();
    chk("R1 ale", ale, 0);
    chk("R1 strobes", {rd_n, wr_n, ub_n, lb_n}, 4'hF);
    chk("R1 oe", {ahi_oe, ad_oe}, 0);
    chk("R1 ready", req_ready, 1);
    chk("R3 free 20-line", io_free, 20'h00000);
  endtask

  task automatic t_read_wide20();
    cfg_wide = 1; cfg_amode = 2'b00; cfg_shift = 0;
    run_access(21'h1ABCD5, 0, 0, 16'h0, 16'hBEEF);
    chk("R2 ale addr phase", a_ale, 1);
    chk("R2 not ready busy", a_ready, 0);
    chk("R9 addr pins", a_pins, 20'hD5E6A);
    chk("R2 addr oe", a_oe, 20'hFFFFF);
    chk("R9 ba0", a_ba0, 1);
    chk("R10 word selects", {a_ub, a_lb}, 2'b00);
    chk("R2 ale low turn", d_ale, 0);
    chk("R6 turn oe", d_oe, 20'hF0000);
    chk("R6 hi addr held", d_pins, 20'hD0000);
    chk("R2 read strobe", {s_rd, s_wr}, 2'b01);
    chk("R13 rsp valid", r_valid, 1);
    chk("R13 rsp data", r_data, 16'hBEEF);
    chk("R2 idle after", {i_rd, i_wr, i_ale}, 3'b110);
  endtask

  task automatic t_narrow20();
    cfg_wide = 0; cfg_amode = 2'b00;
    run_access(21'h012345, 1, 1, 16'h00A7, 16'h0);
    chk("R5 addr pins", a_pins, 20'h091A2);
    chk("R5 write oe", d_oe, 20'hFFFFF);
    chk("R5 write pins", d_pins, 20'h091A7);
    chk("R10 narrow selects", {a_ub, a_lb}, 2'b11);
    chk("R2 write strobe", {s_rd, s_wr}, 2'b10);
    chk("R13 no rsp write", r_valid, 0);
    run_access(21'h012345, 0, 0, 16'h0, 16'h5A3C);
    chk("R5 read oe", d_oe, 20'hFFF00);
    chk("R5 read data", r_data, 16'h003C);
  endtask

  task automatic t_mode16();
    cfg_wide = 1; cfg_amode = 2'b01;
    @(negedge clk);
    chk("R3 free 16-line", io_free, 20'hF0000);
    run_access(21'h1F0F0E, 0, 0, 16'h0, 16'h1234);
    chk("R4 addr pins", a_pins, 20'h08787);
    chk("R4 hi not driven", a_oe, 20'h0FFFF);
    chk("R9 ba0 zero", a_ba0, 0);
  endtask

  task automatic t_mode12();
    cfg_wide = 1; cfg_amode = 2'b10;
    @(negedge clk);
    chk("R3 free 12-line", io_free, 20'hFF000);
    run_access(21'h000246, 1, 0, 16'hFFFF, 16'h0);
    chk("R7 addr pins", a_pins, 20'h00123);
    chk("R7 addr oe", a_oe, 20'h00FFF);
    chk("R7 write oe", d_oe, 20'h00FFF);
    chk("R7 write pins", d_pins, 20'h00FFF);
    run_access(21'h000246, 0, 0, 16'h0, 16'hFFFF);
    chk("R7 read masked", r_data, 16'h0FFF);
    cfg_wide = 0;
    run_access(21'h000ABC, 1, 1, 16'h0055, 16'h0);
    chk("R5 narrow12 oe", d_oe, 20'h00FFF);
    chk("R5 narrow12 pins", d_pins, 20'h00555);
  endtask

  task automatic t_shift();
    cfg_wide = 1; cfg_amode = 2'b00; cfg_shift = 1;
    run_access(21'h020010, 0, 0, 16'h0, 16'h0);
    chk("R8 shifted pins", a_pins, 20'h00008);
    cfg_shift = 0;
    run_access(21'h020010, 0, 0, 16'h0, 16'h0);
    chk("R8 raw pins", a_pins, 20'h10008);
  endtask

  task automatic t_bytes();
    cfg_wide = 1; cfg_amode = 2'b00;
    run_access(21'h000101, 1, 1, 16'h003C, 16'h0);
    chk("R10 odd selects", {a_ub, a_lb}, 2'b01);
    chk("R10 odd lane", d_pins[15:0], 16'h3C00);
    chk("R9 odd ba0", a_ba0, 1);
    run_access(21'h000100, 1, 1, 16'h003C, 16'h0);
    chk("R10 even selects", {a_ub, a_lb}, 2'b10);
    chk("R10 even lane", d_pins[15:0], 16'h003C);
  endtask

  task automatic t_disabled();
    logic seen;
    cfg_amode = 2'b11;
    seen = 0;
    @(negedge clk);
    req_valid = 1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (ale || !rd_n || !wr_n || ad_oe != 0 || ahi_oe != 0) seen = 1;
    end
    req_valid = 0;
    chk("R11 no activity", seen, 0);
    chk("R11 ready low", req_ready, 0);
    chk("R11 all free", io_free, 20'hFFFFF);
  endtask

  task automatic t_bus_off();
    logic seen;
    cfg_amode = 2'b10; cfg_bus_off = 1;
    seen = 0;
    @(negedge clk);
    chk("R12 all free", io_free, 20'hFFFFF);
    chk("R12 ready low", req_ready, 0);
    req_valid = 1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (ale) seen = 1;
    end
    req_valid = 0;
    chk("R12 no start", seen, 0);
    cfg_bus_off = 0;
    @(negedge clk);
    chk("R12 freed kept", io_free & 20'hFF000, 20'hFF000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_read_wide20();
    t_narrow20();
    t_mode16();
    t_mode12();
    t_shift();
    t_bytes();
    t_disabled();
    t_bus_off();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule